// File: doc/BRIEF.md
# Register-Bus Request Responder

This block answers single-cycle requests from an internal processor bus and serves a small bank of read/write registers. A request is a one-cycle strobe that carries a write flag, an address and write data. These are sampled only in the strobe cycle. Writes take effect and are acknowledged in the same cycle. Reads travel through a fixed pipeline of `RD_LAT` stages (at least one) and are acknowledged that many cycles after the request.

Reads and writes have separate acknowledge outputs, and each has its own error flag. The requester may issue a request every cycle, and acknowledges return in request order. A read stays outstanding from the cycle after its request up to and including its acknowledge cycle. During that time the write-stall output is high. A write presented while stall is high is neither performed nor acknowledged. The requester keeps presenting it, and it completes in the first cycle stall is low. This stops a write from finishing ahead of an earlier read.

An address at or above `NUM_REGS` maps to no register. Such a request is still acknowledged, with its error flag set, and the register bank does not change. Reset is synchronous and active high.

Top module: `regbus_responder`

## Requirements
- R1: While reset is high and in the first cycle after it, all acknowledge, error and stall outputs are 0 and `rd_data` is 0. Every register then reads back 0.
- R2: A write to a mapped address with stall low raises `wr_ack` in the request cycle with `wr_err` 0. A read issued in the next cycle returns the new value.
- R3: A read request (`req`=1, `req_wr`=0) raises `rd_ack` exactly `RD_LAT` cycles after the request cycle. In that cycle `rd_err` is 0 and `rd_data` holds the register content as it was in the request cycle.
- R4: Reads issued on consecutive cycles are acknowledged on consecutive cycles, in request order, each with its own data.
- R5: `wr_stall` is high from the cycle after a read request through that read's acknowledge cycle. A write presented while it is high gets no `wr_ack` and leaves the register unchanged.
- R6: A write held through a stall completes, with `wr_ack`, in the first cycle `wr_stall` is low. It is held for exactly `RD_LAT` cycles after a lone read.
- R7: A read of an unmapped address (address >= `NUM_REGS`, here 12..15) is acknowledged after `RD_LAT` cycles with `rd_err`=1 and `rd_data`=0.
- R8: A write to an unmapped address is acknowledged in its cycle with `wr_err`=1 and changes no register.
- R9: Outside an acknowledge cycle `rd_data` is 0. Each error flag is 0 whenever its acknowledge is 0.
- R10: With `req` low, changes on `req_wr`, `req_addr` and `req_wdata` produce no acknowledge and change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Request strobe, one cycle per request |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Register address |
| req_wdata | input | DATA_W | Write data |
| rd_ack | output | 1 | Read acknowledge |
| rd_err | output | 1 | Read error, valid with `rd_ack` |
| rd_data | output | DATA_W | Read data, valid with `rd_ack` |
| wr_ack | output | 1 | Write acknowledge |
| wr_err | output | 1 | Write error, valid with `wr_ack` |
| wr_stall | output | 1 | Holds back a write while reads are outstanding |

## Verification
The bench runs with a two-stage read latency, so that "one cycle later" cannot be mistaken for "`RD_LAT` cycles later". It applies:
- a lone read after a write, which separates same-cycle write completion from registered read timing;
- a burst of four back-to-back reads of distinct values, which exposes reordering, dropped acknowledges or a wrong pipeline depth;
- a write held behind a read to the same register, which shows whether stall covers the acknowledge cycle, whether the read returns the old value, and whether the write lands once stall drops;
- reads and writes to unmapped addresses, followed by a full readback, which separate error signalling from corruption of the bank.

// File: rtl/regbus_responder.sv
module regbus_responder #(
  parameter int ADDR_W   = 4,
  parameter int DATA_W   = 16,
  parameter int NUM_REGS = 12,
  parameter int RD_LAT   = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req,
  input  logic              req_wr,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rd_ack,
  output logic              rd_err,
  output logic [DATA_W-1:0] rd_data,
  output logic              wr_ack,
  output logic              wr_err,
  output logic              wr_stall
);

  localparam int IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;
  localparam logic [ADDR_W:0] LIMIT = NUM_REGS[ADDR_W:0];
  localparam int CW = $clog2(RD_LAT + 1) + 1;

  logic [DATA_W-1:0] regs [NUM_REGS];
  logic [RD_LAT-1:0] pv, pe;
  logic [DATA_W-1:0] pd [RD_LAT];

  logic hit, rd_go, wr_go;
  logic [IDX_W-1:0] idx;
  logic [DATA_W-1:0] rd_val;

  assign hit    = {1'b0, req_addr} < LIMIT;
  assign idx    = req_addr[IDX_W-1:0];
  assign rd_val = hit ? regs[idx] : '0;

  assign wr_stall = |pv;
  assign rd_go    = req & ~req_wr;
  assign wr_go    = req & req_wr & ~wr_stall;

  assign wr_ack  = wr_go;
  assign wr_err  = wr_go & ~hit;
  assign rd_ack  = pv[RD_LAT-1];
  assign rd_err  = pe[RD_LAT-1];
  assign rd_data = pd[RD_LAT-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_REGS; i++) regs[i] <= '0;
    end else if (wr_go && hit) begin
      regs[idx] <= req_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pv <= '0;
      pe <= '0;
      for (int i = 0; i < RD_LAT; i++) pd[i] <= '0;
    end else begin
      pv[0] <= rd_go;
      pe[0] <= rd_go & ~hit;
      pd[0] <= rd_go ? rd_val : '0;
      for (int i = 1; i < RD_LAT; i++) begin
        pv[i] <= pv[i-1];
        pe[i] <= pe[i-1];
        pd[i] <= pd[i-1];
      end
    end
  end

  logic [CW-1:0] inflight;
  always_ff @(posedge clk) begin
    if (rst) inflight <= '0;
    else begin
      case ({rd_go, rd_ack})
        2'b10:   inflight <= inflight + CW'(1);
        2'b01:   inflight <= inflight - CW'(1);
        default: inflight <= inflight;
      endcase
    end
  end

  a_r3_ack_has_request: assert property (@(posedge clk) disable iff (rst)
    rd_ack |-> (inflight != '0));
  a_r4_inflight_bound: assert property (@(posedge clk) disable iff (rst)
    inflight <= CW'(RD_LAT));
  a_r5_stall_while_pending: assert property (@(posedge clk) disable iff (rst)
    (inflight != '0) |-> wr_stall);
  a_r5_stall_drop_after_ack: assert property (@(posedge clk) disable iff (rst)
    $fell(wr_stall) |-> $past(rd_ack));
  a_r2_wr_ack_needs_write: assert property (@(posedge clk) disable iff (rst)
    wr_ack |-> (req && req_wr));
  a_r9_rd_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !rd_ack |-> (rd_data == '0 && !rd_err));
  a_r9_wr_err_with_ack: assert property (@(posedge clk) disable iff (rst)
    !wr_ack |-> !wr_err);

endmodule

// File: tb/regbus_responder_bench.sv
module regbus_responder_bench;
  localparam int P   = 10;
  localparam int LAT = 2;
  localparam int AW  = 4;
  localparam int DW  = 16;
  localparam int NR  = 12;

  logic clk = 0, rst = 1;
  logic req = 0, req_wr = 0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic rd_ack, rd_err, wr_ack, wr_err, wr_stall;
  logic [DW-1:0] rd_data;

  logic o_rack, o_rerr, o_wack, o_werr, o_stall;
  logic [DW-1:0] o_rdata;
  logic [DW-1:0] model [NR];
  int nchk = 0, nfail = 0;

  always #(P/2) clk = ~clk;

  regbus_responder #(.ADDR_W(AW), .DATA_W(DW), .NUM_REGS(NR), .RD_LAT(LAT)) u_regbus_responder (
    .clk(clk), .rst(rst), .req(req), .req_wr(req_wr), .req_addr(req_addr),
    .req_wdata(req_wdata), .rd_ack(rd_ack), .rd_err(rd_err), .rd_data(rd_data),
    .wr_ack(wr_ack), .wr_err(wr_err), .wr_stall(wr_stall));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick(input logic r, input logic w, input logic [AW-1:0] a, input logic [DW-1:0] d);
    req = r; req_wr = w; req_addr = a; req_wdata = d;
    #(P/2);
    o_rack = rd_ack; o_rerr = rd_err; o_rdata = rd_data;
    o_wack = wr_ack; o_werr = wr_err; o_stall = wr_stall;
    @(posedge clk); #1;
  endtask

  task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
    tick(1, 1, a, d);
    chk("R2 wr_ack", o_wack, 1);
    chk("R2/R8 wr_err", o_werr, (a >= NR));
    if (a < NR) model[a] = d;
  endtask

  task automatic do_read(input logic [AW-1:0] a, input string tag);
    logic bad;
    bad = (a >= NR);
    tick(1, 0, a, '0);
    chk({tag, " rd_ack early"}, o_rack, 0);
    for (int c = 1; c <= LAT; c++) begin
      tick(0, 0, '0, '0);
      chk("R5 stall during read", o_stall, 1);
      if (c < LAT) begin
        chk({tag, " rd_ack early"}, o_rack, 0);
        chk("R9 rd_data idle", o_rdata, 0);
      end else begin
        chk({tag, " rd_ack"}, o_rack, 1);
        chk({tag, " rd_err"}, o_rerr, bad);
        chk({tag, " rd_data"}, o_rdata, bad ? '0 : model[a]);
      end
    end
  endtask

  task automatic t_reset();
    rst = 1;
    tick(0, 0, '0, '0);
    chk("R1 rd_ack", o_rack, 0);
    chk("R1 wr_stall", o_stall, 0);
    chk("R1 rd_data", o_rdata, 0);
    rst = 0;
    tick(0, 0, '0, '0);
    chk("R1 outputs after reset", {o_rack, o_rerr, o_wack, o_werr, o_stall}, 0);
    for (int i = 0; i < NR; i++) model[i] = '0;
    do_read(3, "R1 read zero");
  endtask

  task automatic t_write_read();
    do_write(2, 16'hA5C3);
    do_read(2, "R2/R3");
    do_write(11, 16'h0F0F);
    do_read(11, "R3 top reg");
  endtask

  task automatic t_back_to_back();
    for (int i = 0; i < 4; i++) do_write(i[AW-1:0], 16'h1110 + i[DW-1:0]);
    for (int t = 0; t < 4 + LAT + 1; t++) begin
      if (t < 4) tick(1, 0, t[AW-1:0], '0);
      else tick(0, 0, '0, '0);
      if (t >= LAT && t < LAT + 4) begin
        chk("R4 b2b rd_ack", o_rack, 1);
        chk("R4 b2b rd_data order", o_rdata, model[t - LAT]);
      end else begin
        chk("R4 b2b no ack", o_rack, 0);
      end
    end
  endtask

  task automatic t_stall();
    int held;
    logic done;
    do_write(5, 16'h0001);
    tick(1, 0, 5, '0);
    held = 0; done = 0;
    for (int c = 1; c <= LAT + 3 && !done; c++) begin
      tick(1, 1, 5, 16'hBEEF);
      if (c == LAT) begin
        chk("R3 read before held write", o_rack, 1);
        chk("R3 old value", o_rdata, 16'h0001);
      end
      if (o_wack) done = 1;
      else begin
        held++;
        chk("R5 stall with no wr_ack", o_stall, 1);
      end
    end
    tick(0, 0, '0, '0);
    chk("R6 write accepted", done, 1);
    chk("R6 held cycles", held, LAT);
    model[5] = 16'hBEEF;
    do_read(5, "R6 value after stall");
  endtask

  task automatic t_unmapped();
    do_read(12, "R7 unmapped read");
    do_read(15, "R7 unmapped read");
    do_write(13, 16'hDEAD);
    for (int i = 0; i < NR; i++) do_read(i[AW-1:0], "R8 bank intact");
  endtask

  task automatic t_idle_inputs();
    for (int i = 0; i < 6; i++) begin
      tick(0, 1, i[AW-1:0], 16'h7777);
      chk("R10 no wr_ack", o_wack, 0);
      chk("R10 no rd_ack", o_rack, 0);
      chk("R9 idle errs", {o_rerr, o_werr}, 0);
    end
    for (int i = 0; i < 6; i++) do_read(i[AW-1:0], "R10 regs unchanged");
  endtask

  initial begin
    #(P*100000);
    nfail++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    @(posedge clk); #1;
    t_reset();
    t_write_read();
    t_back_to_back();
    t_stall();
    t_unmapped();
    t_idle_inputs();
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule